// File: doc/BRIEF.md
# Leading-Zero Count Normalizer

This block takes an unsigned magnitude word and shifts it left until its highest set bit sits in the top position. It also reports how many places the word moved, which is the leading-zero count. The typical uses are to normalize a mantissa before a floating-point pack, or to size an operand before a divider or a logarithm stage.

The datapath is a chain of 2:1 multiplexer layers. The first layer offers the widest shift, half the word width. Each later layer offers half the shift of the one before it, and the last layer shifts by one. Each layer looks at the top bits of what the previous layer produced. If they are all clear, it takes the shift, and that decision is one bit of the count. No separate priority encoder exists.

A word presented with the valid input is sampled on a rising clock edge, and the result appears on registered outputs after that same edge. The result is the normalized word, the count and an all-zero flag.

Top module: `lzn_top`

## Requirements
- R1: While the synchronous active-high reset is asserted, out_valid, out_norm, out_count and out_zero are all 0 after the next rising edge, whatever the inputs.
- R2: out_valid is 1 in the cycle after an edge that sampled in_valid = 1, and 0 in the cycle after an edge that sampled in_valid = 0 (one cycle of latency).
- R3: For a nonzero sampled word, bit DATA_W-1 of out_norm is 1.
- R4: For a sampled word, out_count equals the number of consecutive zero bits counted from bit DATA_W-1 downward before the first one.
- R5: out_norm equals the sampled word shifted left by out_count places, with zeros filled in at the bottom.
- R6: An all-zero sampled word gives out_count = DATA_W, out_zero = 1 and out_norm = 0.
- R7: An edge with in_valid = 0 leaves out_norm, out_count and out_zero unchanged, whatever in_data holds.
- R8: out_count is $clog2(DATA_W)+1 bits wide and never exceeds DATA_W, and out_zero is 1 exactly when out_count equals DATA_W. DATA_W must be a power of two; for DATA_W = 8 the count is 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample in_data on this edge |
| in_data | input | DATA_W | Unsigned magnitude word |
| out_valid | output | 1 | Result registers loaded on the previous edge |
| out_norm | output | DATA_W | Word shifted left so its top set bit is at DATA_W-1 |
| out_count | output | $clog2(DATA_W)+1 | Leading-zero count, which is also the shift amount |
| out_zero | output | 1 | The sampled word was all zeros |

## Verification
A wrong select in any layer changes two outputs in the same cycle. The count bit of that layer's weight is wrong, and the normalized word either loses bits off the top or keeps a zero in its top bit. Either error is visible one edge after the word is sampled. A wrong decision that depends on a stray bit below the tested window shows only for some bit patterns. The narrow instance is therefore driven with every value, and the wide one with a single one at each position plus random words of varied leading-zero runs. Errors in the all-zero path show as a count of DATA_W-1 instead of DATA_W, or as a missing flag.

// File: rtl/lzn_pkg.sv
`timescale 1ns/1ps
package lzn_pkg;
  // number of shift layers for a power-of-two data width
  function automatic int layer_count(input int width);
    return $clog2(width);
  endfunction

  // shift offered by layer g (layer 0 sits at the input)
  function automatic int layer_shift(input int width, input int g);
    return width >> (g + 1);
  endfunction
endpackage

// File: rtl/lzn_shift_layer.sv
`timescale 1ns/1ps
module lzn_shift_layer #(
  parameter int DATA_W = 32,
  parameter int SHIFT  = 16
) (
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              take
);
  // shift when the top SHIFT bits hold nothing
  always_comb begin
    take = ~|din[DATA_W-1 -: SHIFT];
    dout = take ? (din << SHIFT) : din;
  end
endmodule

// File: rtl/lzn_core.sv
`timescale 1ns/1ps
module lzn_core
  import lzn_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LAYERS = layer_count(DATA_W),
  localparam int CNT_W  = LAYERS + 1
) (
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] norm,
  output logic [CNT_W-1:0]  count,
  output logic              is_zero
);
  logic [DATA_W-1:0] stage [0:LAYERS];
  logic [LAYERS-1:0] sel;

  assign stage[0] = word;

  for (genvar g = 0; g < LAYERS; g++) begin : g_layer
    lzn_shift_layer #(
      .DATA_W(DATA_W),
      .SHIFT (layer_shift(DATA_W, g))
    ) u_layer (
      .din (stage[g]),
      .dout(stage[g+1]),
      .take(sel[LAYERS-1-g])
    );
  end

  // after all layers a nonzero word has its top bit set
  always_comb begin
    is_zero = ~stage[LAYERS][DATA_W-1];
    norm    = stage[LAYERS];
    count   = is_zero ? CNT_W'(DATA_W) : {1'b0, sel};
  end
endmodule

// File: rtl/lzn_top.sv
`timescale 1ns/1ps
module lzn_top #(
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [DATA_W-1:0]         in_data,
  output logic                      out_valid,
  output logic [DATA_W-1:0]         out_norm,
  output logic [$clog2(DATA_W):0]   out_count,
  output logic                      out_zero
);
  localparam int CNT_W = $clog2(DATA_W) + 1;

  logic [DATA_W-1:0] c_norm;
  logic [CNT_W-1:0]  c_count;
  logic              c_zero;

  lzn_core #(.DATA_W(DATA_W)) u_core (
    .word   (in_data),
    .norm   (c_norm),
    .count  (c_count),
    .is_zero(c_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_norm  <= '0;
      out_count <= '0;
      out_zero  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_norm  <= c_norm;
        out_count <= c_count;
        out_zero  <= c_zero;
      end
    end
  end
endmodule

// File: rtl/lzn_checker.sv
`timescale 1ns/1ps
module lzn_checker #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_norm,
  input logic [CNT_W-1:0]  out_count,
  input logic              out_zero
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && out_norm == '0 && out_count == '0 && !out_zero));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r3_top_bit_set: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_zero) |-> out_norm[DATA_W-1]);

  a_r5_shift_match: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_norm == ($past(in_data) << out_count)));

  a_r6_zero_result: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data == '0) |=> (out_zero && out_norm == '0
                                     && out_count == CNT_W'(DATA_W)));

  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_norm) && $stable(out_count) && $stable(out_zero)));

  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    out_count <= CNT_W'(DATA_W));

  a_r8_zero_iff_full: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_zero == (out_count == CNT_W'(DATA_W))));
endmodule

bind lzn_top lzn_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_data  (in_data),
  .out_valid(out_valid),
  .out_norm (out_norm),
  .out_count(out_count),
  .out_zero (out_zero)
);

// File: tb/lzn_top_tb.sv
`timescale 1ns/1ps
module lzn_top_tb;
  localparam int WW  = 32;
  localparam int WN  = 8;
  localparam int CWW = $clog2(WW) + 1;
  localparam int CWN = $clog2(WN) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic           wv = 1'b0, nv = 1'b0;
  logic [WW-1:0]  wd = '0;
  logic [WN-1:0]  nd = '0;
  logic           wov, nov, wz, nz;
  logic [WW-1:0]  wn;
  logic [WN-1:0]  nn;
  logic [CWW-1:0] wc;
  logic [CWN-1:0] nc;

  lzn_top #(.DATA_W(WW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(wv), .in_data(wd),
    .out_valid(wov), .out_norm(wn), .out_count(wc), .out_zero(wz)
  );

  lzn_top #(.DATA_W(WN)) u_dut8 (
    .clk(clk), .rst(rst), .in_valid(nv), .in_data(nd),
    .out_valid(nov), .out_norm(nn), .out_count(nc), .out_zero(nz)
  );

  int n_chk  = 0;
  int n_fail = 0;

  function automatic int lz_ref(input logic [63:0] v, input int w);
    for (int i = w - 1; i >= 0; i--)
      if (v[i]) return w - 1 - i;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // called at a falling edge: drive, let one rising edge pass
  task automatic step_w(input logic v, input logic [WW-1:0] d);
    wv = v; wd = d;
    @(negedge clk);
  endtask

  task automatic step_n(input logic v, input logic [WN-1:0] d);
    nv = v; nd = d;
    @(negedge clk);
  endtask

  task automatic expect_w(input logic [WW-1:0] d);
    int lz = lz_ref({32'b0, d}, WW);
    logic [WW-1:0] en = d << lz;
    chk(wov == 1'b1, "R2", "wide valid", wov, 1);
    chk(wc == CWW'(lz), "R4", "wide count", wc, lz);
    chk(wn == en, "R5", "wide norm", wn, en);
    if (d != '0) chk(wn[WW-1] == 1'b1, "R3", "wide top bit", wn[WW-1], 1);
    chk(wz == (d == '0), "R6", "wide zero flag", wz, (d == '0));
    chk(wz == (wc == CWW'(WW)), "R8", "wide flag vs count", wz, (wc == CWW'(WW)));
  endtask

  task automatic t_reset();
    wv = 1'b1; wd = 32'h0000_1234; nv = 1'b1; nd = 8'h05;
    repeat (3) @(negedge clk);
    chk(wov == 0 && nov == 0, "R1", "valid in reset", {wov, nov}, 0);
    chk(wn == '0 && nn == '0, "R1", "norm in reset", wn, 0);
    chk(wc == '0 && nc == '0, "R1", "count in reset", wc, 0);
    chk(wz == 0 && nz == 0, "R1", "zero in reset", {wz, nz}, 0);
    wv = 1'b0; nv = 1'b0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_latency();
    step_w(1'b1, 32'h0040_0000);
    expect_w(32'h0040_0000);
    step_w(1'b0, 32'h0000_0001);
    chk(wov == 1'b0, "R2", "valid drops after idle edge", wov, 0);
  endtask

  task automatic t_exhaustive8();
    for (int v = 0; v < 256; v++) begin
      int lz = lz_ref(64'(v), WN);
      logic [WN-1:0] en = 8'(v) << lz;
      step_n(1'b1, 8'(v));
      chk(nc == CWN'(lz), "R4", "narrow count", nc, lz);
      chk(nn == en, "R5", "narrow norm", nn, en);
      if (v != 0) chk(nn[WN-1] == 1'b1, "R3", "narrow top bit", nn, en);
      chk(nz == (v == 0), "R6", "narrow zero flag", nz, (v == 0));
      chk(nc <= CWN'(WN), "R8", "narrow count bound", nc, WN);
    end
    nv = 1'b0;
  endtask

  task automatic t_wide_patterns();
    for (int p = 0; p < WW; p++) begin
      step_w(1'b1, 32'b1 << p);
      expect_w(32'b1 << p);
    end
    step_w(1'b1, 32'hFFFF_FFFF);
    expect_w(32'hFFFF_FFFF);
    step_w(1'b1, 32'h0000_0000);
    chk(wc == CWW'(WW) && wz && wn == '0, "R6", "wide all-zero", wc, WW);
    for (int k = 0; k < 300; k++) begin
      logic [WW-1:0] d = $urandom >> ($urandom % 33);
      step_w(1'b1, d);
      expect_w(d);
    end
  endtask

  task automatic t_hold();
    step_w(1'b1, 32'h0001_8000);
    expect_w(32'h0001_8000);
    for (int k = 0; k < 4; k++) begin
      step_w(1'b0, 32'(k));
      chk(wov == 1'b0, "R7", "valid low while idle", wov, 0);
      chk(wc == CWW'(15), "R7", "count held", wc, 15);
      chk(wn == 32'hC000_0000, "R7", "norm held", wn, 32'hC000_0000);
      chk(wz == 1'b0, "R7", "zero held", wz, 0);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_latency();
    t_exhaustive8();
    t_wide_patterns();
    t_hold();
    report();
  end
endmodule